// File: doc/BRIEF.md
# Tower-Field Byte Inverter

This block returns the multiplicative inverse of one byte taken as an element of GF(2^8), built as a degree-two extension over GF(2^4). The byte holds two nibbles. The high nibble is the coefficient of the extension variable and the low nibble is the constant term. The arithmetic over the byte reduces first to a single nibble inversion, and a handful of nibble multipliers and squarers surround it. That nibble inversion is not a computation. The nibble walks a four-level binary decision tree one bit at a time, and the leaf it reaches has a fixed link to the leaf that holds its inverse.

The block takes one operand on every clock and returns its inverse a fixed number of cycles later. A zero operand has no inverse. For a zero operand the block outputs zero and raises a flag. Operands must already be in the tower representation. The block does no basis conversion.

Top module: `gftw_inverter`

## Requirements
- R1: The nibble inverter walks a four-level tree from the most significant bit to the least. At each level a 0 bit takes the left child and a 1 bit takes the right child, so every nibble reaches exactly one of 16 leaves.
- R2: Each leaf links to the leaf of its GF(2^4) inverse, reduced by x^4 + x + 1. Leaf 0001 links to itself and leaf 0000 yields 0000. For a byte input 0x0v, v nonzero, the output is 0x0w with v·w = 1 in GF(2^4).
- R3: For every nonzero byte a = {ah, al}, meaning ah·x + al with x^2 = x + 9, the output b satisfies a·b = 1. Nibble bit i is the coefficient of x^i.
- R4: An input of 0x00 gives output 0x00 with zero_flag = 1. Any nonzero input gives zero_flag = 0 and a nonzero output.
- R5: The result for an input sampled at clock edge k appears after edge k+1 when IN_STAGE = 1, and after edge k when IN_STAGE = 0. A new operand is accepted on every cycle.
- R6: Reset is synchronous and active low. After a reset edge, inv_out = 0x00 and zero_flag = 1, and these values stay until results of post-reset inputs arrive.
- R7: Inversion is an involution. Feeding the output back returns the original byte, and 0x01 maps to 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| elem_in | input | 8 | Operand, high nibble = coefficient of x |
| inv_out | output | 8 | Registered inverse of the operand |
| zero_flag | output | 1 | Registered flag: operand was zero |

## Verification
The bench sweeps all 256 operands back to back and compares every cycle against a brute-force search model. This exposes a swapped tree direction or a mislinked leaf as a wrong byte for a specific set of operands. Bytes with a zero high nibble isolate the nibble tree. A bad link or a reversed bit order there shows up as a low nibble that fails v·w = 1. A wrong constant 9 or a conjugate using the wrong nibble breaks the product check on most nonzero bytes, and the involution pass catches a non-bijective table. Zero input, reset values and a reset during streaming are checked as well. A wrong flag or leftover data in a stage register would show up as a nonzero output after reset.

// File: rtl/gftw_pkg.sv
// Shared types and elaboration-time helpers for the tower-field inverter.
// Assumes nibble bit i is the coefficient of x^i; field poly x^4 + x + 1.
package gftw_pkg;

    typedef logic [3:0] nib_t;
    typedef logic [7:0] elem_t;

    // Low part of the nibble field polynomial: x^4 = x + 1.
    localparam nib_t NIB_POLY_LOW = 4'h3;

    // Behavioural nibble product, used only for constants and assertions.
    function automatic nib_t nib_mul_f(input nib_t a, input nib_t b);
        logic [6:0] acc;
        acc = '0;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ (7'(a) << i);
        end
        for (int k = 6; k >= 4; k--) begin
            if (acc[k]) acc = acc ^ (7'(5'h13) << (k - 4));
        end
        return acc[3:0];
    endfunction

    // Byte product in the tower with x^2 = x + k.
    function automatic elem_t elem_mul_f(input elem_t a, input elem_t b, input nib_t k);
        nib_t hh, hl, lh, ll;
        hh = nib_mul_f(a[7:4], b[7:4]);
        hl = nib_mul_f(a[7:4], b[3:0]);
        lh = nib_mul_f(a[3:0], b[7:4]);
        ll = nib_mul_f(a[3:0], b[3:0]);
        return {hh ^ hl ^ lh, ll ^ nib_mul_f(k, hh)};
    endfunction

    // Leaf link table packed as 16 nibbles: entry v holds the inverse of v.
    function automatic logic [63:0] build_links();
        logic [63:0] t;
        t = '0;
        for (int v = 1; v < 16; v++) begin
            for (int w = 1; w < 16; w++) begin
                if (nib_mul_f(nib_t'(v), nib_t'(w)) == 4'h1) t[v*4 +: 4] = nib_t'(w);
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/gftw_nib_mul.sv
// GF(2^4) multiplier: a 4x4 AND partial-product array folded into seven
// column sums, then reduced with x^4 = x + 1. Purely combinational.
module gftw_nib_mul
    import gftw_pkg::*;
(
    input  nib_t a,
    input  nib_t b,
    output nib_t p
);
    logic [6:0] col;

    // Accumulate partial products into their columns.
    always_comb begin
        col = '0;
        for (int j = 0; j < 4; j++) begin
            for (int k = 0; k < 4; k++) begin
                col[j+k] = col[j+k] ^ (a[j] & b[k]);
            end
        end
    end

    // Fold columns 4..6 back using x^4 = x+1, x^5 = x^2+x, x^6 = x^3+x^2.
    always_comb begin
        p[0] = col[0] ^ col[4];
        p[1] = col[1] ^ col[4] ^ col[5];
        p[2] = col[2] ^ col[5] ^ col[6];
        p[3] = col[3] ^ col[6];
    end
endmodule

// File: rtl/gftw_nib_sqr.sv
// GF(2^4) squarer: squaring is linear over GF(2), so it is a fixed XOR
// network. Assumes reduction by x^4 + x + 1.
module gftw_nib_sqr
    import gftw_pkg::*;
(
    input  nib_t a,
    output nib_t s
);
    // Spread bits to even powers and fold x^4, x^6 back into range.
    always_comb begin
        s[0] = a[0] ^ a[2];
        s[1] = a[2];
        s[2] = a[1] ^ a[3];
        s[3] = a[3];
    end
endmodule

// File: rtl/gftw_nib_scale.sv
// GF(2^4) multiply by a constant K: XOR of the shifted copies a*x^i picked
// by the set bits of K. Assumes reduction by x^4 + x + 1.
module gftw_nib_scale
    import gftw_pkg::*;
#(
    parameter nib_t K = 4'h9
) (
    input  nib_t a,
    output nib_t y
);
    nib_t pw   [4];
    nib_t part [5];

    assign pw[0]   = a;
    assign part[0] = '0;

    for (genvar i = 1; i < 4; i++) begin : g_pow
        // Multiply the previous power by x.
        assign pw[i] = {pw[i-1][2:0], 1'b0} ^ (pw[i-1][3] ? NIB_POLY_LOW : 4'h0);
    end

    for (genvar i = 0; i < 4; i++) begin : g_sum
        if (K[i]) begin : g_on
            assign part[i+1] = part[i] ^ pw[i];
        end else begin : g_off
            assign part[i+1] = part[i];
        end
    end

    assign y = part[4];
endmodule

// File: rtl/gftw_nib_tree_inv.sv
// GF(2^4) inverter by tree walk: node n (heap numbering, root 1) has left
// child 2n for a 0 bit and right child 2n+1 for a 1 bit, MSB first. Each of
// the 16 leaves carries a fixed link to its inverse; zero links to zero.
module gftw_nib_tree_inv
    import gftw_pkg::*;
(
    input  nib_t nib_in,
    output nib_t nib_out
);
    localparam int LEVELS = 4;
    localparam int NODES  = 2 ** (LEVELS + 1);
    localparam int LEAF0  = 2 ** LEVELS;
    localparam logic [63:0] LINKS = build_links();

    logic [NODES-1:1] act;
    assign act[1] = 1'b1;

    for (genvar n = 2; n < NODES; n++) begin : g_node
        localparam int LVL = $clog2(n + 1) - 1;
        localparam int BIT = LEVELS - LVL;
        if (n % 2 == 1) begin : g_right
            assign act[n] = act[n/2] & nib_in[BIT];
        end else begin : g_left
            assign act[n] = act[n/2] & ~nib_in[BIT];
        end
    end

    // Follow the link of the single active leaf.
    always_comb begin
        nib_out = '0;
        for (int v = 0; v < LEAF0; v++) begin
            if (act[LEAF0 + v]) nib_out = nib_out | LINKS[v*4 +: 4];
        end
    end

    // Guards on the walk and the links.
    always_comb begin
        assert_leaf_onehot_R1: assert ($onehot(act[NODES-1:LEAF0]))
            else $error("tree walk did not reach exactly one leaf");
        assert_leaf_link_R2: assert (nib_in == 4'h0 || nib_mul_f(nib_in, nib_out) == 4'h1)
            else $error("leaf link does not give the nibble inverse");
    end
endmodule

// File: rtl/gftw_inverter.sv
// Tower-field byte inverter. Operand a = ah*x + al with x^2 = x + K.
// delta = K*ah^2 ^ ah*al ^ al^2, d = 1/delta (tree walk),
// result = (ah*d)*x + (ah^al)*d. Zero maps to zero with zero_flag set.
// Optional input register (IN_STAGE), always a registered output.
module gftw_inverter
    import gftw_pkg::*;
#(
    parameter bit   IN_STAGE = 1'b1,
    parameter nib_t TOWER_K  = 4'h9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  elem_in,
    output logic [7:0]  inv_out,
    output logic        zero_flag
);
    elem_t opnd;
    nib_t  ah, al, sq_h, sq_l, k_sq_h, p_hl, delta, d_inv, res_h, res_l, sum_hl;
    logic  is_zero;

    if (IN_STAGE) begin : g_in_reg
        // Capture the operand to shorten the path into the tree.
        always_ff @(posedge clk) begin
            if (!rst_n) opnd <= '0;
            else        opnd <= elem_in;
        end
    end else begin : g_in_wire
        assign opnd = elem_in;
    end

    assign ah      = opnd[7:4];
    assign al      = opnd[3:0];
    assign sum_hl  = ah ^ al;
    assign is_zero = (opnd == '0);

    gftw_nib_sqr  u_sq_h (.a(ah), .s(sq_h));
    gftw_nib_sqr  u_sq_l (.a(al), .s(sq_l));
    gftw_nib_scale #(.K(TOWER_K)) u_scale (.a(sq_h), .y(k_sq_h));
    gftw_nib_mul  u_m_hl (.a(ah), .b(al), .p(p_hl));

    assign delta = k_sq_h ^ p_hl ^ sq_l;

    gftw_nib_tree_inv u_tree (.nib_in(delta), .nib_out(d_inv));

    gftw_nib_mul  u_m_hi (.a(ah),     .b(d_inv), .p(res_h));
    gftw_nib_mul  u_m_lo (.a(sum_hl), .b(d_inv), .p(res_l));

    // Register the result and the zero indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_out   <= '0;
            zero_flag <= 1'b1;
        end else begin
            inv_out   <= {res_h, res_l};
            zero_flag <= is_zero;
        end
    end

    // Combinational guards on the tower formula.
    always_comb begin
        assert_delta_nonzero_R3: assert (is_zero || delta != 4'h0)
            else $error("norm is zero for a nonzero operand");
        assert_product_one_R3: assert (is_zero || elem_mul_f(opnd, {res_h, res_l}, TOWER_K) == 8'h01)
            else $error("operand times result is not one");
    end

    assert_zero_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> inv_out == 8'h00);
    assert_nonzero_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_flag |-> inv_out != 8'h00);
    assert_reset_state_R6: assert property (@(posedge clk)
        !rst_n |=> (inv_out == 8'h00 && zero_flag));
endmodule

// File: tb/gftw_inverter_test.sv
`timescale 1ns/1ps
module gftw_inverter_test;
    localparam int LAT = 2;  // IN_STAGE = 1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] elem_in = 8'h00;
    logic [7:0] inv_out;
    logic       zero_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit armed  = 0;
    int inv16 [16];
    int inv256 [256];

    always #4 clk = ~clk;

    gftw_inverter #(.IN_STAGE(1'b1), .TOWER_K(4'h9)) uut (
        .clk(clk), .rst_n(rst_n), .elem_in(elem_in),
        .inv_out(inv_out), .zero_flag(zero_flag)
    );

    // Reference nibble product by shift-and-add and polynomial reduction.
    function automatic int rmul16(int a, int b);
        int r = 0;
        for (int i = 0; i < 4; i++) if ((b >> i) & 1) r = r ^ (a << i);
        for (int k = 6; k >= 4; k--) if ((r >> k) & 1) r = r ^ ('h13 << (k - 4));
        return r & 'hF;
    endfunction

    // Reference byte product with x^2 = x + 9.
    function automatic int rmul256(int a, int b);
        int ah = a >> 4, al = a & 15, bh = b >> 4, bl = b & 15;
        int hh = rmul16(ah, bh);
        int hi = hh ^ rmul16(ah, bl) ^ rmul16(al, bh);
        int lo = rmul16(al, bl) ^ rmul16(9, hh);
        return (hi << 4) | lo;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Cycle model: a queue of expected outputs, one entry per register stage.
    typedef struct packed { logic [7:0] v; logic f; } exp_t;
    exp_t pipe [$];

    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            pipe.delete();
            for (int i = 0; i < LAT; i++) pipe.push_back('{v: 8'h00, f: 1'b1});
            armed <= 1'b1;
        end else begin
            e.v = 8'(inv256[elem_in]);
            e.f = (elem_in == 8'h00);
            pipe.push_back(e);
            while (pipe.size() > LAT) void'(pipe.pop_front());
        end
    end

    // Compare every cycle, away from the active edge (R5 timing).
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (inv_out !== pipe[0].v || zero_flag !== pipe[0].f) begin
                errors++;
                $display("FAIL R5 cycle model: got %0h/%0b expected %0h/%0b",
                         inv_out, zero_flag, pipe[0].v, pipe[0].f);
            end
        end
    end

    task automatic run_one(input logic [7:0] v, output logic [7:0] o, output logic f);
        @(negedge clk) elem_in = v;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        o = inv_out;
        f = zero_flag;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R5: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] o, o2;
        logic f;
        for (int v = 0; v < 16; v++) begin
            inv16[v] = 0;
            for (int w = 1; w < 16; w++) if (v != 0 && rmul16(v, w) == 1) inv16[v] = w;
        end
        for (int a = 0; a < 256; a++) begin
            inv256[a] = 0;
            for (int b = 1; b < 256; b++) if (a != 0 && rmul256(a, b) == 1) inv256[a] = b;
        end

        // R6: reset values.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset out", inv_out, 0);
        check("R6 reset flag", zero_flag, 1);
        rst_n = 1'b1;

        // R4: zero operand.
        run_one(8'h00, o, f);
        check("R4 zero out", o, 0);
        check("R4 zero flag", f, 1);

        // R1 R2: nibble-only operands exercise the tree and its links.
        for (int v = 1; v < 16; v++) begin
            run_one(8'(v), o, f);
            check("R2 high nibble", o[7:4], 0);
            check("R1 R2 leaf link", o[3:0], inv16[v]);
        end

        // R3 R4: product with every nonzero byte is one.
        for (int a = 1; a < 256; a++) begin
            run_one(8'(a), o, f);
            check("R3 product", rmul256(a, o), 1);
            check("R4 flag low", f, 0);
        end

        // R7: involution and the unit element.
        run_one(8'h01, o, f);
        check("R7 unit", o, 1);
        for (int a = 1; a < 256; a += 3) begin
            run_one(8'(a), o, f);
            run_one(o, o2, f);
            check("R7 involution", o2, a);
        end

        // R5: back-to-back stream, checked by the cycle model.
        for (int v = 0; v < 256; v++) begin
            @(negedge clk) elem_in = 8'(255 - v);
        end
        repeat (LAT + 1) @(negedge clk);

        // R6: reset in the middle of traffic.
        @(negedge clk) elem_in = 8'h53;
        @(negedge clk) elem_in = 8'hA7;
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 mid-run out", inv_out, 0);
        check("R6 mid-run flag", zero_flag, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 stage cleared out", inv_out, 0);
        check("R6 stage cleared flag", zero_flag, 1);
        @(negedge clk);
        check("R5 after reset", inv_out, inv256[8'hA7]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule